// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with a 36-bit word made of four 9-bit byte lanes. All control, address and data inputs are registered on the rising clock edge. Read data passes through an array read register and then an output register. As a result, the first word of a burst appears two edges after the edge that captured its request, and each later word follows one clock after the one before it.

An access begins when either of two address strobes is asserted while the three chip enables all sit in their active state. The processor strobe always starts a read. The controller strobe samples the write controls, so it starts either a read or a write. After the start, a two-bit counter on the two low address bits supplies the remaining three addresses of the burst. The counter steps once for each cycle with the advance input asserted. It follows a linear order or an interleaved order, chosen by a mode input that is sampled with the strobe.

Write gating merges two paths. A global write stores every lane. Otherwise, a byte-write enable lets each lane select store its own lane. The output enable gates the data outputs without a register. A sleep input makes the block ignore every strobe and every advance. The address width is a parameter: the full-size device uses 16 bits, and the default elaboration uses a smaller array.

Top module: `sram_burst_pipe`

## Requirements
- R1: While reset is high and in the first cycle after reset, dout is all zero and dout_vld is 0.
- R2: For a read captured at clock edge k, dout and dout_vld=1 are presented from just after edge k+2 until edge k+3. A burst delivers one word per clock while advance is held low.
- R3: With seq_lin=0 sampled at the strobe, burst beat c (0..3) accesses the address whose two low bits are start XOR c. The upper bits are unchanged.
- R4: With seq_lin=1 sampled at the strobe, burst beat c accesses low bits (start + c) mod 4, wrapping inside the aligned group of four. The upper bits are unchanged.
- R5: The burst counter steps only on a cycle with adv_n=0 and no strobe. A cycle with adv_n=1 and no strobe performs no access, so dout_vld is 0 in its output slot, and the next advance continues with the next beat.
- R6: gw_n=0 on a write cycle stores all 36 bits of din.
- R7: With gw_n=1 and bwe_n=0, lane i (bits 9i+8 down to 9i) is stored only when bw_n[i]=0. With gw_n=1 and bwe_n=1, the cycle is a read and no lane is stored.
- R8: A cycle with adsp_n=0 starts a read whatever gw_n, bwe_n and bw_n are. It takes priority over adsc_n.
- R9: A strobe is accepted only if ce_a_n=0, ce_b=1 and ce_c_n=0 at that edge. Otherwise no access happens, later advances are ignored, memory is unchanged and dout_vld stays 0.
- R10: oe_n=1 forces dout to zero and dout_vld to 0 within the same cycle, with no clock edge. Whenever dout_vld is 0, dout is zero.
- R11: While sleep=1, strobes and advances are ignored and nothing is written. After sleep returns to 0, accesses work normally.
- R12: Advance cycles after a controller-strobe write, with the write controls still active, store din at the successive burst addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Low-power request; blocks all new operations |
| addr | input | ADDR_W | Word address, loaded on a strobe |
| din | input | 36 | Write data, four 9-bit lanes |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low, read only |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| seq_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 36 | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid |

## Verification
A burst counter that steps wrongly, or a mode latched at the wrong time, shows up at the second beat of a burst. That happens two edges after the first advance, so dout carries a word stored at a different address. The bench fills every address with a distinct pattern so that such a word never matches. A wrong lane mask or lost chip-select state stays hidden until the address is read back. The bench therefore follows each write, ignored strobe and sleep period with a full burst read. An output enable wrongly placed behind a register would show as a one-cycle lag in dout at the moment oe_n toggles.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int CNT_W  = 2;

    typedef enum logic {
        SEQ_INTERLEAVED = 1'b0,
        SEQ_LINEAR      = 1'b1
    } seq_e;

    // One registered array request
    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] data;
    } acc_t;

    function automatic logic [CNT_W-1:0] burst_off(input logic [CNT_W-1:0] start,
                                                   input logic [CNT_W-1:0] cnt,
                                                   input seq_e             mode);
        if (mode == SEQ_LINEAR)
            return CNT_W'(start + cnt);
        return start ^ cnt;
    endfunction
endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sleep,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        din,
    input  logic                     ce_ok,
    input  logic                     adsp_n,
    input  logic                     adsc_n,
    input  logic                     adv_n,
    input  logic                     seq_lin,
    input  logic                     gw_n,
    input  logic                     bwe_n,
    input  logic [LANES-1:0]         bw_n,
    output acc_t                     acc_q,
    output logic [ADDR_W-1:0]        acc_addr,
    output logic [CNT_W-1:0]         cnt_q
);
    logic [ADDR_W-1:0] base_q;
    logic              sel_q;
    seq_e              mode_q;
    logic              strobe;
    logic [LANES-1:0]  wmask;

    assign strobe = !adsp_n || !adsc_n;
    assign wmask  = !gw_n  ? {LANES{1'b1}} :
                    !bwe_n ? ~bw_n          : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            sel_q  <= 1'b0;
            mode_q <= SEQ_INTERLEAVED;
            acc_q  <= '0;
        end else if (sleep) begin
            acc_q.vld <= 1'b0;
            acc_q.wr  <= 1'b0;
        end else if (strobe) begin
            base_q     <= addr;
            cnt_q      <= '0;
            sel_q      <= ce_ok;
            mode_q     <= seq_e'(seq_lin);
            acc_q.vld  <= ce_ok;
            acc_q.wr   <= ce_ok && adsp_n && (|wmask);
            acc_q.be   <= adsp_n ? wmask : '0;
            acc_q.data <= din;
        end else if (!adv_n && sel_q) begin
            cnt_q      <= cnt_q + CNT_W'(1);
            acc_q.vld  <= 1'b1;
            acc_q.wr   <= |wmask;
            acc_q.be   <= wmask;
            acc_q.data <= din;
        end else begin
            acc_q.vld <= 1'b0;
            acc_q.wr  <= 1'b0;
        end
    end

    assign acc_addr = {base_q[ADDR_W-1:CNT_W], burst_off(base_q[CNT_W-1:0], cnt_q, mode_q)};
endmodule

// File: rtl/sram_burst_array.sv
module sram_burst_array
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [WORD_W-1:0] rd_q,
    output logic              rd_vld_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (acc.vld && acc.wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (acc.be[l])
                    mem[acc_addr][l*LANE_W +: LANE_W] <= acc.data[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_q <= 1'b0;
            rd_q     <= '0;
        end else begin
            rd_vld_q <= acc.vld && !acc.wr;
            rd_q     <= mem[acc_addr];
        end
    end
endmodule

// File: rtl/sram_burst_out.sv
module sram_burst_out
    import sram_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rd_q,
    input  logic              rd_vld_q,
    input  logic              oe_n,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld
);
    logic [WORD_W-1:0] q_data;
    logic              q_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_data <= '0;
            q_vld  <= 1'b0;
        end else begin
            q_data <= rd_q;
            q_vld  <= rd_vld_q;
        end
    end

    assign dout_vld = q_vld && !oe_n;
    assign dout     = dout_vld ? q_data : '0;
endmodule

// File: rtl/sram_burst_pipe.sv
module sram_burst_pipe
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [35:0]       din,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              seq_lin,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [3:0]        bw_n,
    input  logic              oe_n,
    output logic [35:0]       dout,
    output logic              dout_vld
);
    acc_t              acc_q;
    logic [ADDR_W-1:0] acc_addr;
    logic [CNT_W-1:0]  burst_cnt;
    logic [WORD_W-1:0] rd_q;
    logic              rd_vld_q;
    logic              ce_ok;

    assign ce_ok = !ce_a_n && ce_b && !ce_c_n;

    sram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .sleep(sleep), .addr(addr), .din(din),
        .ce_ok(ce_ok), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .seq_lin(seq_lin), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .acc_q(acc_q), .acc_addr(acc_addr), .cnt_q(burst_cnt)
    );

    sram_burst_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .acc(acc_q), .acc_addr(acc_addr),
        .rd_q(rd_q), .rd_vld_q(rd_vld_q)
    );

    sram_burst_out u_out (
        .clk(clk), .rst(rst), .rd_q(rd_q), .rd_vld_q(rd_vld_q),
        .oe_n(oe_n), .dout(dout), .dout_vld(dout_vld)
    );
endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk
    import sram_burst_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sleep,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              ce_ok,
    input logic              oe_n,
    input logic              acc_vld,
    input logic              acc_wr,
    input logic [CNT_W-1:0]  burst_cnt,
    input logic              dout_vld,
    input logic [WORD_W-1:0] dout
);
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !acc_wr) |=> ##1 (dout_vld || oe_n)); // R2

    AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!sleep && (!adsp_n || !adsc_n)) |=> (burst_cnt == '0)); // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (adv_n && adsp_n && adsc_n) |=> $stable(burst_cnt)); // R5

    AST_PROC_READ: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !adsp_n) |=> !acc_wr); // R8

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!sleep && (!adsp_n || !adsc_n) && !ce_ok) |=> !acc_vld); // R9

    AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_vld); // R10

    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dout_vld |-> (dout == '0)); // R10

    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !acc_vld); // R11
endmodule

bind sram_burst_pipe sram_burst_chk u_chk (
    .clk(clk), .rst(rst), .sleep(sleep), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce_ok(ce_ok), .oe_n(oe_n), .acc_vld(acc_q.vld),
    .acc_wr(acc_q.wr), .burst_cnt(burst_cnt), .dout_vld(dout_vld), .dout(dout)
);

// File: tb/tb_sram_burst_pipe.sv
module tb_sram_burst_pipe;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [35:0]   din = '0;
    logic          ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, seq_lin = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          oe_n = 1'b0;
    logic [35:0]   dout;
    logic          dout_vld;

    logic [35:0]   ref_mem [1<<AW];
    int            n_chk = 0;
    int            n_fail = 0;

    always #10 clk = ~clk;

    sram_burst_pipe #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .sleep(sleep), .addr(addr), .din(din),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adsp_n(adsp_n),
        .adsc_n(adsc_n), .adv_n(adv_n), .seq_lin(seq_lin), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(input bit ok, input string req, input logic [36:0] act, input logic [36:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] beat_off(input logic [1:0] s, input int c, input bit lin);
        int v;
        v = lin ? (int'(s) + c) % 4 : (int'(s) ^ c);
        return 2'(v);
    endfunction

    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
    endtask

    // Write burst by controller strobe; updates reference model
    task automatic wr_burst(input logic [AW-1:0] a, input int nb, input bit lin,
                            input logic gwn, input logic bwen, input logic [3:0] bwn,
                            input logic [35:0] seed);
        for (int b = 0; b < nb; b++) begin
            logic [AW-1:0] wa;
            logic [35:0]   d;
            @(negedge clk);
            d = seed + 36'(b) * 36'h0_1357_9BD1;
            if (b == 0) begin
                adsc_n = 1'b0; addr = a; seq_lin = lin; adv_n = 1'b1;
            end else begin
                adsc_n = 1'b1; adv_n = 1'b0;
            end
            gw_n = gwn; bwe_n = bwen; bw_n = bwn; din = d;
            wa = {a[AW-1:2], beat_off(a[1:0], b, lin)};
            for (int l = 0; l < 4; l++)
                if (!gwn || (!bwen && !bwn[l]))
                    ref_mem[wa][l*9 +: 9] = d[l*9 +: 9];
        end
        @(negedge clk);
        idle();
    endtask

    // Four-beat read; optional hold cycle after beat 0; optional write noise on a processor strobe
    task automatic rd_burst(input logic [AW-1:0] a, input bit use_p, input bit lin,
                            input bit gap, input bit noise, input string req);
        int          slots;
        bit          ev [5];
        logic [35:0] ex [5];
        int          b;
        slots = gap ? 5 : 4;
        b = 0;
        for (int s = 0; s < slots; s++) begin
            ev[s] = !(gap && s == 1);
            ex[s] = '0;
            if (ev[s]) begin
                ex[s] = ref_mem[{a[AW-1:2], beat_off(a[1:0], b, lin)}];
                b++;
            end
        end
        for (int i = 0; i < slots + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                if (ev[i-3])
                    check(dout_vld && dout == ex[i-3], req, {dout_vld, dout}, {1'b1, ex[i-3]});
                else
                    check(!dout_vld && dout == '0, {req, "/R5 hold"}, {dout_vld, dout}, 37'd0);
            end
            idle();
            if (i < slots) begin
                if (i == 0) begin
                    addr = a; seq_lin = lin;
                    if (use_p) adsp_n = 1'b0; else adsc_n = 1'b0;
                    if (noise) begin
                        gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'h0; din = '1;
                        adsc_n = 1'b0;
                    end
                end else begin
                    adv_n = ev[i] ? 1'b0 : 1'b1;
                end
            end
        end
    endtask

    task automatic expect_silent(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle();
            check(!dout_vld && dout == '0, req, {dout_vld, dout}, 37'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!dout_vld && dout == '0, "R1 in reset", {dout_vld, dout}, 37'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!dout_vld && dout == '0, "R1 after reset", {dout_vld, dout}, 37'd0);

        // R6: fill every word with a global-write burst
        for (int g = 0; g < (1 << AW) / 4; g++)
            wr_burst(AW'(g * 4), 4, 1'b1, 1'b0, 1'b1, 4'hF, 36'(g) * 36'h1_0203_0405 + 36'h5A5);
        rd_burst(6'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R6 gw fill");

        // R2 R3 R4: every start offset, both orders, both strobes
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int g = 0; g < 16; g += 5) begin
                    rd_burst(AW'(g * 4 + s), 1'b0, bit'(m), 1'b0, 1'b0, m ? "R4 linear R2" : "R3 interleaved R2");
                    rd_burst(AW'(g * 4 + s), 1'b1, bit'(m), 1'b0, 1'b0, m ? "R4 linear adsp" : "R3 interleaved adsp");
                end

        // R12: burst writes from non-zero starts in both orders
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++) begin
                wr_burst(AW'(32 + s), 4, bit'(m), 1'b0, 1'b1, 4'hF, 36'h9_0000_0000 + 36'(m * 16 + s));
                rd_burst(6'd32, 1'b1, 1'b1, 1'b0, 1'b0, "R12 burst write");
            end

        // R5: hold cycle inside a burst
        for (int m = 0; m < 2; m++)
            rd_burst(6'd13, 1'b0, bit'(m), 1'b1, 1'b0, "R5 advance hold");

        // R7: every lane mask, then bwe_n high with lanes selected
        for (int k = 0; k < 16; k++) begin
            wr_burst(6'd40, 1, 1'b0, 1'b1, 1'b0, ~4'(k), 36'h1_2345_6789 * 36'(k + 1));
            rd_burst(6'd40, 1'b1, 1'b0, 1'b0, 1'b0, "R7 lane mask");
        end
        wr_burst(6'd41, 1, 1'b0, 1'b1, 1'b1, 4'h0, 36'hF_FFFF_FFFF);
        rd_burst(6'd40, 1'b0, 1'b0, 1'b0, 1'b0, "R7 bwe_n high no write");

        // R8: processor strobe with write controls active and adsc also low
        rd_burst(6'd24, 1'b1, 1'b0, 1'b0, 1'b1, "R8 adsp read");
        rd_burst(6'd24, 1'b0, 1'b0, 1'b0, 1'b0, "R8 no write done");

        // R9: each chip enable inactive in turn, write attempt, advances, read attempt
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            idle();
            ce_a_n = (w == 0); ce_b = (w != 1); ce_c_n = (w == 2);
            adsc_n = 1'b0; addr = 6'd48; gw_n = 1'b0; din = '1;
            @(negedge clk);
            idle();
            adv_n = 1'b0; gw_n = 1'b0;
            @(negedge clk);
            idle();
            adsp_n = 1'b0; addr = 6'd48;
            @(negedge clk);
            idle();
            ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
            expect_silent(4, "R9 deselected");
            rd_burst(6'd48, 1'b0, 1'b1, 1'b0, 1'b0, "R9 memory unchanged");
        end

        // R10: asynchronous output enable inside a valid slot
        @(negedge clk);
        adsp_n = 1'b0; addr = 6'd7; seq_lin = 1'b0;
        @(negedge clk);
        idle();
        @(negedge clk);
        @(negedge clk);
        oe_n = 1'b1;
        #2;
        check(!dout_vld && dout == '0, "R10 oe_n high", {dout_vld, dout}, 37'd0);
        oe_n = 1'b0;
        #2;
        check(dout_vld && dout == ref_mem[7], "R10 oe_n low", {dout_vld, dout}, {1'b1, ref_mem[7]});

        // R11: sleep blocks strobes, writes and advances
        @(negedge clk);
        sleep = 1'b1;
        @(negedge clk);
        adsc_n = 1'b0; addr = 6'd20; gw_n = 1'b0; din = '1;
        @(negedge clk);
        idle();
        adv_n = 1'b0; gw_n = 1'b0;
        @(negedge clk);
        idle();
        adsp_n = 1'b0; addr = 6'd20;
        @(negedge clk);
        idle();
        expect_silent(4, "R11 sleeping");
        sleep = 1'b0;
        rd_burst(6'd20, 1'b0, 1'b0, 1'b0, 1'b0, "R11 resume unchanged");
        wr_burst(6'd20, 4, 1'b0, 1'b0, 1'b1, 4'hF, 36'h3_3333_0000);
        rd_burst(6'd20, 1'b1, 1'b0, 1'b0, 1'b0, "R11 resume write");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule